// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Gate

This block keeps the status byte of a serial flash device and decides, command by command, whether an operation that changes stored data may start. The command decoder hands it single-cycle strobes for the write-latch set and clear commands, status write, page program, the three erase sizes, and entry to and exit from the one-time-programmable (OTP) mode. With each strobe it also gives the target block index. The block combines these strobes with the write-latch state, the busy state, the block-protect field, the hardware-protect pin and the OTP lock. It answers with a one-cycle grant pulse for the accepted command, or with no pulse when the command is refused.

The non-volatile fields are a status-register-protect bit, a protect-pin-disable bit, the four-bit block-protect field and the OTP lock. They are held in flip-flops. A status write reaches them only after a programmable number of cycles, and the busy flag stays high for that whole time. For array operations the busy flag follows the array sequencer's busy line. The write latch clears by itself when any accepted modifying operation finishes. In OTP mode a status write ignores its data and sets the one-time lock instead.

Top module: `flash_wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, no grant is asserted and `otp_lock` is 0.
- R2: The status byte carries busy in bit 0 and the write latch in bit 1. Bits 5:2 hold the block-protect field, with its most significant bit in bit 5. Bit 6 is the protect-pin-disable bit. Bit 7 shows the status-register-protect bit outside OTP mode and the OTP lock inside OTP mode.
- R3: The write-enable strobe sets the write latch, visible in the next cycle, and the write-disable strobe clears it. No other strobe sets it.
- R4: A modifying command (status write, program, any erase) is granted only when the write latch was set. A refused command leaves the write latch unchanged.
- R5: A granted command raises exactly one bit of `grant` for one cycle, in the cycle after its strobe. Bit 0 is status write, bit 1 program, bit 2 sector erase, bit 3 block erase and bit 4 chip erase.
- R6: Busy rises in the cycle after a grant. After a status write it stays high for exactly WR_DELAY cycles. After an array operation it stays high until the first cycle in which `array_busy` is sampled low after having been sampled high. The write latch clears at the same edge at which busy falls.
- R7: Every modifying command issued while busy is high is refused, and the write latch is kept.
- R8: A status write outside OTP mode is refused when status-register-protect is 1, `wp_n` is 0 and protect-pin-disable is 0. When protect-pin-disable is 1 the pin has no effect.
- R9: Let n be the block-protect value. A value of 0 protects nothing. A value n of 1 or more protects the top 2^(n-1) blocks, up to the whole array. Outside OTP mode, program, sector erase and block erase aimed at a protected block are refused. Chip erase is refused whenever n is not 0.
- R10: A granted status write outside OTP mode copies data bits 7:2 into status bits 7:2 at the edge at which busy falls.
- R11: A granted status write in OTP mode ignores its data and sets `otp_lock` to 1 when busy falls. No command clears the lock.
- R12: In OTP mode, program, sector erase and block erase are refused once the lock is 1, and a status write is refused as well. Chip erase is always refused in OTP mode.
- R13: The OTP enter and exit strobes take effect in the next cycle only when busy is low; otherwise they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_pp | input | 1 | Page-program strobe |
| cmd_se | input | 1 | Sector-erase strobe |
| cmd_be | input | 1 | Block-erase strobe |
| cmd_ce | input | 1 | Chip-erase strobe |
| cmd_otp_enter | input | 1 | Enter OTP mode strobe |
| cmd_otp_exit | input | 1 | Leave OTP mode strobe |
| wrsr_data | input | 8 | Data byte of a status write |
| tgt_block | input | ADDR_W-BLK_W | Block index of the target address |
| wp_n | input | 1 | Write-protect pin, active low |
| array_busy | input | 1 | Busy line from the array sequencer |
| status | output | 8 | Readable status byte |
| grant | output | 5 | One-hot grant pulse per modifying command |
| otp_lock | output | 1 | OTP sector lock |

## Verification
The gate is tried with program and erase requests aimed both just inside and just outside the protected top blocks. The block-protect values used are one, two and the saturating maximum, so an off-by-one or a missing saturation in the region decode shows up as a wrong grant. Status writes are tried in four pin and bit combinations of the hardware-protect mode. This separates a protect-pin-disable bit that is ignored from a pin that is ignored. Requests issued while busy, or without the write latch, test the refusal path and also test that the write latch survives a refusal. The OTP sequence tries commands before and after the lock is set, then leaves the mode. This shows that bit 7 switches its meaning and that the lock stays set.

// File: rtl/flash_wprot_pkg.sv
// Package: shared layout constants and types of the flash status/protect gate.
// Assumes nothing beyond the bit layout named in the brief.
package flash_wprot_pkg;

    // Status byte positions
    localparam int ST_WIP   = 0;
    localparam int ST_WEL   = 1;
    localparam int ST_BP_LO = 2;
    localparam int ST_BP_HI = 5;
    localparam int ST_WPDIS = 6;
    localparam int ST_SRP   = 7;

    // Grant vector positions
    localparam int GR_WRSR  = 0;
    localparam int GR_PP    = 1;
    localparam int GR_SE    = 2;
    localparam int GR_BE    = 3;
    localparam int GR_CE    = 4;
    localparam int GR_W     = 5;

    // Non-volatile portion of the status register
    typedef struct packed {
        logic       srp;
        logic       wpdis;
        logic [3:0] bp;
    } nv_bits_t;

endpackage

// File: rtl/wprot_region_chk.sv
// Module: block-protect region decode.
// Value 0 protects nothing; value n protects the top 2^(n-1) blocks,
// saturating at the whole array. Purely combinational.
module wprot_region_chk #(
    parameter int BIDX_W = 6
) (
    input  logic [3:0]        bp,
    input  logic [BIDX_W-1:0] blk,
    output logic              hit
);
    localparam int            NBLK   = 1 << BIDX_W;
    localparam logic [BIDX_W:0] NBLK_V = (BIDX_W+1)'(NBLK);

    logic [BIDX_W:0] span;

    // Size of the protected region in blocks
    always_comb begin
        if (bp == 4'd0)
            span = '0;
        else if (32'(bp) > BIDX_W)
            span = NBLK_V;
        else
            span = (BIDX_W+1)'(1) << (bp - 4'd1);
    end

    // Target lies inside the protected top region
    assign hit = (bp != 4'd0) && ({1'b0, blk} >= (NBLK_V - span));

endmodule

// File: rtl/wprot_nv_store.sv
// Module: non-volatile status bits and OTP lock with a timed write.
// A start pulse captures data; after WR_DELAY cycles the data (or, in OTP
// mode, the lock) is committed. Assumes start only arrives when not busy
// and WR_DELAY >= 1.
module wprot_nv_store
    import flash_wprot_pkg::*;
#(
    parameter int       WR_DELAY = 8,
    parameter nv_bits_t NV_INIT  = '0,
    parameter logic     LOCK_INIT = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     otp_sel,
    input  nv_bits_t wdata,
    output nv_bits_t nv,
    output logic     lock,
    output logic     busy,
    output logic     done
);
    localparam int CNT_W = $clog2(WR_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_DELAY);

    logic [CNT_W-1:0] cnt;
    nv_bits_t         pend;
    logic             pend_otp;

    // Last busy cycle of a timed write
    assign done = busy && (cnt == CNT_W'(1));

    // Timed write: capture, count down, commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv       <= NV_INIT;
            lock     <= LOCK_INIT;
            busy     <= 1'b0;
            cnt      <= '0;
            pend     <= '0;
            pend_otp <= 1'b0;
        end else if (busy) begin
            if (done) begin
                busy <= 1'b0;
                if (pend_otp)
                    lock <= 1'b1;
                else
                    nv <= pend;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= CNT_LOAD;
            pend     <= wdata;
            pend_otp <= otp_sel;
        end
    end

endmodule

// File: rtl/flash_wprot_ctrl.sv
// Module: flash status register and write-protection gate (top).
// Grants modifying commands according to write latch, busy, hardware and
// software protection and OTP lock; tracks array busy and self-clears the
// write latch on completion. Assumes at most one command strobe per cycle
// and that the array sequencer raises array_busy after a grant.
module flash_wprot_ctrl
    import flash_wprot_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int BLK_W    = 16,
    parameter int WR_DELAY = 8,
    localparam int BIDX_W  = ADDR_W - BLK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic              cmd_otp_enter,
    input  logic              cmd_otp_exit,
    input  logic [7:0]        wrsr_data,
    input  logic [BIDX_W-1:0] tgt_block,
    input  logic              wp_n,
    input  logic              array_busy,
    output logic [7:0]        status,
    output logic [GR_W-1:0]   grant,
    output logic              otp_lock
);
    nv_bits_t nv;
    nv_bits_t nv_wdata;
    logic     sr_busy, sr_done;
    logic     arr_active, arr_seen, arr_done;
    logic     wel, otp_mode;
    logic     wip, hpm, may_modify, blk_hit, tgt_ok;
    logic     g_wrsr, g_pp, g_se, g_be, g_ce, g_arr;
    logic [GR_W-1:0] grant_q;

    assign nv_wdata = nv_bits_t'(wrsr_data[7:2]);

    wprot_nv_store #(
        .WR_DELAY (WR_DELAY)
    ) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (g_wrsr),
        .otp_sel (otp_mode),
        .wdata   (nv_wdata),
        .nv      (nv),
        .lock    (otp_lock),
        .busy    (sr_busy),
        .done    (sr_done)
    );

    wprot_region_chk #(
        .BIDX_W (BIDX_W)
    ) u_region (
        .bp  (nv.bp),
        .blk (tgt_block),
        .hit (blk_hit)
    );

    // Protection and grant decision for the strobe of this cycle
    always_comb begin
        wip        = sr_busy | arr_active;
        hpm        = nv.srp & ~wp_n & ~nv.wpdis;
        may_modify = wel & ~wip;
        tgt_ok     = otp_mode ? ~otp_lock : ~blk_hit;
        g_wrsr     = cmd_wrsr & may_modify & (otp_mode ? ~otp_lock : ~hpm);
        g_pp       = cmd_pp & may_modify & tgt_ok;
        g_se       = cmd_se & may_modify & tgt_ok;
        g_be       = cmd_be & may_modify & tgt_ok;
        g_ce       = cmd_ce & may_modify & ~otp_mode & (nv.bp == 4'd0);
        g_arr      = g_pp | g_se | g_be | g_ce;
    end

    // Registered one-hot grant pulse
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant_q <= '0;
        else begin
            grant_q          <= '0;
            grant_q[GR_WRSR] <= g_wrsr;
            grant_q[GR_PP]   <= g_pp;
            grant_q[GR_SE]   <= g_se;
            grant_q[GR_BE]   <= g_be;
            grant_q[GR_CE]   <= g_ce;
        end
    end

    // Array operation tracking: start on grant, end after busy seen and dropped
    assign arr_done = arr_active & arr_seen & ~array_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_active <= 1'b0;
            arr_seen   <= 1'b0;
        end else if (g_arr) begin
            arr_active <= 1'b1;
            arr_seen   <= 1'b0;
        end else if (arr_active) begin
            if (array_busy)
                arr_seen <= 1'b1;
            else if (arr_seen) begin
                arr_active <= 1'b0;
                arr_seen   <= 1'b0;
            end
        end
    end

    // Write enable latch: set by write enable, cleared by disable or completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (cmd_wren)
            wel <= 1'b1;
        else if (cmd_wrdi | sr_done | arr_done)
            wel <= 1'b0;
    end

    // OTP mode flag, changed only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            otp_mode <= 1'b0;
        else if (!wip) begin
            if (cmd_otp_enter)
                otp_mode <= 1'b1;
            else if (cmd_otp_exit)
                otp_mode <= 1'b0;
        end
    end

    // Status byte assembly
    always_comb begin
        status                  = '0;
        status[ST_WIP]          = wip;
        status[ST_WEL]          = wel;
        status[ST_BP_HI:ST_BP_LO] = nv.bp;
        status[ST_WPDIS]        = nv.wpdis;
        status[ST_SRP]          = otp_mode ? otp_lock : nv.srp;
    end

    assign grant = grant_q;

endmodule

// File: rtl/flash_wprot_ctrl_chk.sv
// Checker: temporal properties of the status/protect gate, bound to the top.
module flash_wprot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       wp_n,
    input logic [7:0] status,
    input logic [4:0] grant,
    input logic       otp_lock,
    input logic       otp_mode
);
    // R4
    grant_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> $past(status[1]));

    // R7
    grant_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> !$past(status[0]));

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6
    wip_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> status[0]);

    // R3
    wel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> $past(cmd_wren));

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(otp_lock));

    // R8
    hpm_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !$past(otp_mode)) |->
        !($past(status[7]) && !$past(wp_n) && !$past(status[6])));

    // R10
    bp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(status[0]) |-> $stable(status[5:2]));

endmodule

bind flash_wprot_ctrl flash_wprot_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wren (cmd_wren),
    .wp_n     (wp_n),
    .status   (status),
    .grant    (grant),
    .otp_lock (otp_lock),
    .otp_mode (otp_mode)
);

// File: tb/flash_wprot_ctrl_bench.sv
module flash_wprot_ctrl_bench;
    localparam int ADDR_W = 22, BLK_W = 16, WR_DELAY = 8;
    localparam int BIDX_W = ADDR_W - BLK_W;
    localparam int NBLK = 1 << BIDX_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0;
    logic cmd_be = 0, cmd_ce = 0, cmd_otp_enter = 0, cmd_otp_exit = 0;
    logic [7:0] wrsr_data = 8'h00;
    logic [BIDX_W-1:0] tgt_block = '0;
    logic wp_n = 1'b1, array_busy = 1'b0;
    logic [7:0] status;
    logic [4:0] grant;
    logic otp_lock;

    int checks = 0, failures = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    flash_wprot_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WR_DELAY(WR_DELAY))
    u_flash_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .cmd_pp(cmd_pp), .cmd_se(cmd_se), .cmd_be(cmd_be),
        .cmd_ce(cmd_ce), .cmd_otp_enter(cmd_otp_enter), .cmd_otp_exit(cmd_otp_exit),
        .wrsr_data(wrsr_data), .tgt_block(tgt_block), .wp_n(wp_n),
        .array_busy(array_busy), .status(status), .grant(grant), .otp_lock(otp_lock)
    );

    // ---------------- behavioural reference model ----------------
    int m_wel, m_sr, m_cnt, m_arr, m_seen, m_otp, m_srp, m_wpd, m_bp, m_lock;
    int m_grant, p_data, p_otp;

    function automatic int prot(int bp, int blk);
        int span;
        if (bp == 0) return 0;
        span = (bp - 1 >= BIDX_W) ? NBLK : (1 << (bp - 1));
        return (blk >= NBLK - span) ? 1 : 0;
    endfunction

    function automatic int exp_status();
        int b7;
        b7 = m_otp ? m_lock : m_srp;
        return (b7 << 7) | (m_wpd << 6) | (m_bp << 2) | (m_wel << 1) |
               ((m_sr | m_arr) ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_sr = 0; m_cnt = 0; m_arr = 0; m_seen = 0; m_otp = 0;
            m_srp = 0; m_wpd = 0; m_bp = 0; m_lock = 0; m_grant = 0;
            p_data = 0; p_otp = 0;
        end else begin
            int busy, okay, tgt, g, nwel, done_now;
            busy = m_sr | m_arr;
            okay = m_wel && !busy;
            tgt  = m_otp ? !m_lock : !prot(m_bp, int'(tgt_block));
            g = 0;
            if (cmd_wrsr && okay && (m_otp ? !m_lock : !(m_srp && !wp_n && !m_wpd))) g = 1;
            if (cmd_pp && okay && tgt) g = 2;
            if (cmd_se && okay && tgt) g = 4;
            if (cmd_be && okay && tgt) g = 8;
            if (cmd_ce && okay && !m_otp && m_bp == 0) g = 16;
            done_now = 0;
            if (m_sr) begin
                if (m_cnt == 1) begin
                    m_sr = 0; done_now = 1;
                    if (p_otp) m_lock = 1;
                    else begin
                        m_srp = (p_data >> 7) & 1; m_wpd = (p_data >> 6) & 1;
                        m_bp = (p_data >> 2) & 15;
                    end
                end else m_cnt--;
            end
            if (m_arr && g == 0) begin
                if (array_busy) m_seen = 1;
                else if (m_seen) begin m_arr = 0; m_seen = 0; done_now = 1; end
            end
            nwel = m_wel;
            if (cmd_wren) nwel = 1;
            else if (cmd_wrdi || done_now) nwel = 0;
            m_wel = nwel;
            if (g == 1) begin m_sr = 1; m_cnt = WR_DELAY; p_data = wrsr_data; p_otp = m_otp; end
            if (g > 1) begin m_arr = 1; m_seen = 0; end
            if (!busy) begin
                if (cmd_otp_enter) m_otp = 1;
                else if (cmd_otp_exit) m_otp = 0;
            end
            m_grant = g;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (status !== 8'(exp_status()) || grant !== 5'(m_grant) || otp_lock !== 1'(m_lock)) begin
                failures++;
                $display("FAIL %s model: status=%h/%h grant=%b/%b lock=%b/%0d (got/exp)",
                         cur_req, status, 8'(exp_status()), grant, 5'(m_grant), otp_lock, m_lock);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string r, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", r, got, exp);
        end
    endtask

    // 0 wren 1 wrdi 2 wrsr 3 pp 4 se 5 be 6 ce 7 otp_enter 8 otp_exit
    task automatic pulse(input int c);
        @(negedge clk);
        case (c)
            0: cmd_wren = 1; 1: cmd_wrdi = 1; 2: cmd_wrsr = 1; 3: cmd_pp = 1;
            4: cmd_se = 1;   5: cmd_be = 1;   6: cmd_ce = 1;   7: cmd_otp_enter = 1;
            default: cmd_otp_exit = 1;
        endcase
        @(negedge clk);
        {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce,
         cmd_otp_enter, cmd_otp_exit} = '0;
    endtask

    task automatic seq_run(input int n);
        @(negedge clk); array_busy = 1;
        repeat (n) @(negedge clk);
        array_busy = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wrsr_go(input string r, input logic [7:0] d, input int exp_g);
        wrsr_data = d;
        pulse(0);
        pulse(2);
        chk(r, int'(grant[0]), exp_g);
        if (exp_g != 0) repeat (WR_DELAY + 1) @(negedge clk);
    endtask

    task automatic arr_go(input string r, input int c, input int blk, input int exp_g);
        tgt_block = BIDX_W'(blk);
        pulse(0);
        pulse(c);
        chk(r, int'(grant[c-2]), exp_g);
        if (exp_g != 0) begin
            seq_run(3);
            chk({r, " done"}, int'(status[1:0]), 0);
        end else begin
            chk({r, " latch kept"}, int'(status[1]), 1);
            pulse(1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1"; chk("R1 status", int'(status), 0); chk("R1 grant", int'(grant), 0);
        chk("R1 lock", int'(otp_lock), 0);

        cur_req = "R4"; tgt_block = 0; pulse(3);
        chk("R4 no latch", int'(grant), 0);
        cur_req = "R3"; pulse(0); chk("R3 set", int'(status[1]), 1);
        pulse(1); chk("R3 clear", int'(status[1]), 0);

        cur_req = "R10";   // data 0x08 -> block-protect 2
        wrsr_data = 8'h08; pulse(0); pulse(2);
        chk("R5 wrsr grant", int'(grant), 1);
        chk("R6 busy", int'(status[0]), 1);
        repeat (WR_DELAY - 1) @(negedge clk);
        chk("R6 busy last", int'(status[0]), 1);
        @(negedge clk);
        chk("R6 busy fell", int'(status[1:0]), 0);
        chk("R10 bp written", int'(status[5:2]), 2);

        cur_req = "R9";
        arr_go("R9 pp top", 3, NBLK - 1, 0);
        arr_go("R9 se edge", 4, NBLK - 2, 0);
        arr_go("R9 pp below", 3, NBLK - 3, 1);
        arr_go("R9 be low", 5, 0, 1);
        arr_go("R9 ce with bp", 6, 0, 0);

        cur_req = "R7";
        tgt_block = 0; pulse(0); pulse(3);
        chk("R7 pp grant", int'(grant), 2);
        pulse(0); pulse(2);
        chk("R7 refused busy", int'(grant), 0);
        chk("R7 latch kept", int'(status[1]), 1);
        seq_run(2);
        chk("R6 latch cleared", int'(status[1:0]), 0);

        cur_req = "R9";
        wrsr_go("R9 bp1", 8'h04, 1);
        arr_go("R9 bp1 top", 4, NBLK - 1, 0);
        arr_go("R9 bp1 next", 4, NBLK - 2, 1);
        wrsr_go("R9 bp15", 8'h3C, 1);
        arr_go("R9 sat", 3, 0, 0);
        wrsr_go("R9 clear", 8'h00, 1);
        arr_go("R9 ce ok", 6, 5, 1);

        cur_req = "R8";
        wrsr_go("R8 srp on", 8'h80, 1);
        wp_n = 0;
        wrsr_go("R8 hpm refuse", 8'h00, 0);
        chk("R8 srp kept", int'(status[7]), 1);
        pulse(1);
        wp_n = 1;
        wrsr_go("R8 pin high", 8'hC0, 1);
        wp_n = 0;
        wrsr_go("R8 disable", 8'h00, 1);
        chk("R8 written", int'(status[7:2]), 0);
        wp_n = 1;

        cur_req = "R13";
        pulse(7); chk("R13 enter", int'(status[7]), 0);
        cur_req = "R12";
        arr_go("R12 pp unlocked", 3, NBLK - 1, 1);
        cur_req = "R11";
        wrsr_go("R11 lock", 8'h00, 1);
        chk("R11 lock set", int'(otp_lock), 1);
        chk("R2 bit7 lock", int'(status[7]), 1);
        chk("R11 data ignored", int'(status[6:2]), 0);
        cur_req = "R12";
        arr_go("R12 pp locked", 3, 0, 0);
        arr_go("R12 se locked", 4, 0, 0);
        arr_go("R12 ce otp", 6, 0, 0);
        wrsr_go("R12 wrsr locked", 8'h00, 0);
        pulse(1);
        cur_req = "R13";
        pulse(8); chk("R13 exit", int'(status[7]), 0);
        chk("R11 lock stays", int'(otp_lock), 1);
        wrsr_data = 8'h00; pulse(0); pulse(2);
        pulse(7);
        chk("R13 ignored busy", int'(status[7]), 0);
        repeat (WR_DELAY + 1) @(negedge clk);
        chk("R13 still normal", int'(status[7]), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule